// File: doc/BRIEF.md
# PWM Action Qualifier

This block turns counter match events into two registered PWM outputs. Each clock it compares an externally supplied time-base counter value with a period value and two compare values. It also samples two trigger inputs. It then decides, for each output, whether to drive the output high, drive it low, invert it, or leave it as it is. Matches against compare A, compare B and the two triggers have separate actions for the up-counting and the down-counting phase. The zero match and the period match each have a single action, whatever the direction.

Each output has a 20-bit action word. Software writes that word into a shadow copy. The copy moves into the active set only at a counter boundary, so a waveform is never reprogrammed partway through a period. When several events fall in the same clock, only one action is applied, chosen by a fixed priority. A force request overrides the event flow for a single clock, on one chosen output.

Top module: `pwm_action_qual`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, both outputs are 0. The active and shadow action words reset to all zero, which means "no action" for every event.
- R2: Action codes are 2 bits wide: 00 = leave the output, 01 = drive 0, 10 = drive 1, 11 = invert the registered value. The new output value appears on the clock edge that samples the event.
- R3: The zero event (`cnt_val`==0) uses action bits [1:0]. The period event (`cnt_val`==`period`) uses bits [3:2]. Both apply in either count direction.
- R4: A compare-A match uses bits [5:4] while `cnt_up`=1 and bits [7:6] while `cnt_up`=0.
- R5: A compare-B match uses bits [9:8] while `cnt_up`=1 and bits [11:10] while `cnt_up`=0.
- R6: A high `trig_1` uses bits [13:12] while counting up and bits [15:14] while counting down. A high `trig_2` uses bits [17:16] and [19:18] in the same way.
- R7: Output 0 and output 1 each have their own action word, selected by `cfg_sel`. A write to one output's word never changes the other output.
- R8: A `cfg_wr` writes only the shadow word, which has no effect until a load point. A load copies the shadow words as they stood before that clock's write. In the load clock itself, actions still come from the old active words.
- R9: With `load_at_prd`=0 the only load point is the zero event. With `load_at_prd`=1 the period event is also a load point.
- R10: When events coincide, only the action of the highest event present applies, even if that action is "leave". The order from highest to lowest is trig_1, trig_2, compare B, compare A, zero, period.
- R11: When `force_en` is high, `force_act` is applied to output `force_sel` in place of any event action, for that clock only. The other output follows its events as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CW | Time-base counter value |
| cnt_up | input | 1 | 1 = counter is counting up |
| period | input | CW | Period value |
| cmp_a | input | CW | Compare A value |
| cmp_b | input | CW | Compare B value |
| trig_1 | input | 1 | Trigger event 1 |
| trig_2 | input | 1 | Trigger event 2 |
| load_at_prd | input | 1 | 1 = the period event is also a load point |
| cfg_wr | input | 1 | Shadow write strobe |
| cfg_sel | input | SW | Output whose shadow word is written |
| cfg_data | input | 20 | Action word to write |
| force_en | input | 1 | One-clock force request |
| force_sel | input | SW | Output to force |
| force_act | input | 2 | Action code to force |
| pwm_out | output | NOUT | Registered PWM outputs |

## Verification
The hardest case to reach is a load clock that is also an event clock and also carries a new shadow write. In that clock the action must come from the old active word, and the write must not be picked up by the load. The bench steps a full counter ramp onto zero while it writes a different word in the same cycle, and it compares the result against its own model of both register sets. A second hard case is events stacking up in one clock. The stimulus places compare A, compare B and the zero point on the same counter value and raises both triggers on top of them, so that the priority order alone decides the result.

// File: rtl/aq_pkg.sv
package aq_pkg;
    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_INV  = 2'b11
    } act_e;

    // first member is most significant: zero sits at [1:0], t2 down at [19:18]
    typedef struct packed {
        act_e t2_dn;
        act_e t2_up;
        act_e t1_dn;
        act_e t1_up;
        act_e cb_dn;
        act_e cb_up;
        act_e ca_dn;
        act_e ca_up;
        act_e on_prd;
        act_e on_zro;
    } aq_cfg_t;

    localparam int CFG_W = $bits(aq_cfg_t);

    typedef struct packed {
        logic up;
        logic t1;
        logic t2;
        logic cb;
        logic ca;
        logic zro;
        logic prd;
    } aq_evt_t;

    function automatic logic apply_act(input act_e a, input logic cur);
        case (a)
            ACT_LOW:  apply_act = 1'b0;
            ACT_HIGH: apply_act = 1'b1;
            ACT_INV:  apply_act = ~cur;
            default:  apply_act = cur;
        endcase
    endfunction
endpackage

// File: rtl/aq_evt_detect.sv
module aq_evt_detect
    import aq_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_up,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] cmp_a,
    input  logic [CW-1:0] cmp_b,
    input  logic          trig_1,
    input  logic          trig_2,
    output aq_evt_t       evt
);
    always_comb begin
        evt     = '0;
        evt.up  = cnt_up;
        evt.t1  = trig_1;
        evt.t2  = trig_2;
        evt.cb  = (cnt_val == cmp_b);
        evt.ca  = (cnt_val == cmp_a);
        evt.zro = (cnt_val == '0);
        evt.prd = (cnt_val == period);
    end
endmodule

// File: rtl/aq_cfg_bank.sv
module aq_cfg_bank
    import aq_pkg::*;
#(
    parameter int NOUT = 2,
    localparam int SW = (NOUT > 1) ? $clog2(NOUT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SW-1:0]        wr_sel,
    input  aq_cfg_t              wr_data,
    input  logic                 load,
    output aq_cfg_t [NOUT-1:0]   active
);
    typedef struct packed {
        aq_cfg_t [NOUT-1:0] sh;
        aq_cfg_t [NOUT-1:0] act;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) st_d.act = st_q.sh;
        for (int i = 0; i < NOUT; i++) begin
            if (wr_en && (int'(wr_sel) == i)) st_d.sh[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;

    // R8: active words only move at a load point
    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.act));
    // R8: a load copies the shadow content from before that clock's write
    assert_load_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.act == $past(st_q.sh)));
endmodule

// File: rtl/aq_out_ctrl.sv
module aq_out_ctrl
    import aq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  aq_evt_t evt,
    input  aq_cfg_t cfg,
    input  logic    frc_en,
    input  act_e    frc_act,
    output logic    out
);
    typedef struct packed {
        logic pin;
    } oc_t;

    oc_t  st_d, st_q;
    act_e pick;

    always_comb begin
        st_d = st_q;
        if (evt.t1)       pick = evt.up ? cfg.t1_up : cfg.t1_dn;
        else if (evt.t2)  pick = evt.up ? cfg.t2_up : cfg.t2_dn;
        else if (evt.cb)  pick = evt.up ? cfg.cb_up : cfg.cb_dn;
        else if (evt.ca)  pick = evt.up ? cfg.ca_up : cfg.ca_dn;
        else if (evt.zro) pick = cfg.on_zro;
        else if (evt.prd) pick = cfg.on_prd;
        else              pick = ACT_KEEP;
        if (frc_en) pick = frc_act;
        st_d.pin = apply_act(pick, st_q.pin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out = st_q.pin;

    // R1: first clock after reset still shows low
    assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !st_q.pin);
    // R2: no event and no force leaves the pin alone
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frc_en && !(evt.t1 || evt.t2 || evt.cb || evt.ca || evt.zro || evt.prd))
        |=> $stable(st_q.pin));
    // R10: trigger 1 on the up ramp outranks every other event
    assert_t1_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frc_en && evt.t1 && evt.up && cfg.t1_up == ACT_HIGH) |=> st_q.pin);
    // R11: force toggle inverts the pin
    assert_force_inv_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_en && frc_act == ACT_INV) |=> (st_q.pin != $past(st_q.pin)));
    // R11: force low wins over any event
    assert_force_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_en && frc_act == ACT_LOW) |=> !st_q.pin);
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
    import aq_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NOUT = 2,
    localparam int SW  = (NOUT > 1) ? $clog2(NOUT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cnt_val,
    input  logic             cnt_up,
    input  logic [CW-1:0]    period,
    input  logic [CW-1:0]    cmp_a,
    input  logic [CW-1:0]    cmp_b,
    input  logic             trig_1,
    input  logic             trig_2,
    input  logic             load_at_prd,
    input  logic             cfg_wr,
    input  logic [SW-1:0]    cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             force_en,
    input  logic [SW-1:0]    force_sel,
    input  logic [1:0]       force_act,
    output logic [NOUT-1:0]  pwm_out
);
    aq_evt_t            evt;
    aq_cfg_t [NOUT-1:0] active;
    logic               load;

    aq_evt_detect #(.CW(CW)) u_evt (
        .cnt_val (cnt_val),
        .cnt_up  (cnt_up),
        .period  (period),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .trig_1  (trig_1),
        .trig_2  (trig_2),
        .evt     (evt)
    );

    assign load = evt.zro | (load_at_prd & evt.prd);

    aq_cfg_bank #(.NOUT(NOUT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_sel  (cfg_sel),
        .wr_data (aq_cfg_t'(cfg_data)),
        .load    (load),
        .active  (active)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        logic fe;
        assign fe = force_en && (int'(force_sel) == g);
        aq_out_ctrl u_oc (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt),
            .cfg     (active[g]),
            .frc_en  (fe),
            .frc_act (act_e'(force_act)),
            .out     (pwm_out[g])
        );
    end
endmodule

// File: tb/pwm_action_qual_bench.sv
module pwm_action_qual_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt_val = '0, period = 16'd8, cmp_a = 16'd3, cmp_b = 16'd5;
    logic          cnt_up = 1'b1, trig_1 = 1'b0, trig_2 = 1'b0, load_at_prd = 1'b0;
    logic          cfg_wr = 1'b0, cfg_sel = 1'b0, force_en = 1'b0, force_sel = 1'b0;
    logic [19:0]   cfg_data = '0;
    logic [1:0]    force_act = '0;
    logic [1:0]    pwm_out;

    int n_chk = 0, n_fail = 0;
    logic [19:0] m_sh [2];
    logic [19:0] m_act[2];
    logic [1:0]  m_out;
    logic [1:0]  exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_action_qual u_pwm_action_qual (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up), .period(period),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .trig_1(trig_1), .trig_2(trig_2),
        .load_at_prd(load_at_prd), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .force_en(force_en), .force_sel(force_sel), .force_act(force_act), .pwm_out(pwm_out)
    );

    function automatic logic [1:0] fld(input logic [19:0] w, input int i);
        return w[2*i +: 2];
    endfunction

    function automatic logic do_act(input logic [1:0] a, input logic cur);
        case (a)
            2'b01: return 1'b0;
            2'b10: return 1'b1;
            2'b11: return ~cur;
            default: return cur;
        endcase
    endfunction

    // drive one cycle of inputs at the falling edge and predict the result
    task automatic step(input logic [CW-1:0] c, input logic up, input logic t1, input logic t2,
                        input logic wr, input logic ws, input logic [19:0] wd,
                        input logic fe, input logic fs, input logic [1:0] fa, input string tag);
        logic zro, prd, ca, cb;
        logic [1:0] nxt;
        @(negedge clk);
        cnt_val = c; cnt_up = up; trig_1 = t1; trig_2 = t2;
        cfg_wr = wr; cfg_sel = ws; cfg_data = wd;
        force_en = fe; force_sel = fs; force_act = fa;
        zro = (c == 0); prd = (c == period); ca = (c == cmp_a); cb = (c == cmp_b);
        for (int o = 0; o < 2; o++) begin
            logic [1:0] a;
            if (t1)       a = up ? fld(m_act[o], 6) : fld(m_act[o], 7);
            else if (t2)  a = up ? fld(m_act[o], 8) : fld(m_act[o], 9);
            else if (cb)  a = up ? fld(m_act[o], 4) : fld(m_act[o], 5);
            else if (ca)  a = up ? fld(m_act[o], 2) : fld(m_act[o], 3);
            else if (zro) a = fld(m_act[o], 0);
            else if (prd) a = fld(m_act[o], 1);
            else          a = 2'b00;
            if (fe && fs == o[0]) a = fa;
            nxt[o] = do_act(a, m_out[o]);
        end
        m_out = nxt;
        if (zro || (load_at_prd && prd)) begin
            m_act[0] = m_sh[0];
            m_act[1] = m_sh[1];
        end
        if (wr) m_sh[ws] = wd;
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic [CW-1:0] c, input logic up, input string tag);
        step(c, up, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 2'b00, tag);
    endtask

    task automatic write(input logic ws, input logic [19:0] wd, input string tag);
        step(16'd1, 1'b1, 1'b0, 1'b0, 1'b1, ws, wd, 1'b0, 1'b0, 2'b00, tag);
    endtask

    // up ramp 0..period-1, down ramp period..1
    task automatic ramp(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < int'(period); c++) idle(c[CW-1:0], 1'b1, tag);
            for (int c = int'(period); c > 0; c--) idle(c[CW-1:0], 1'b0, tag);
        end
    endtask

    // monitor: compare outputs one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (pwm_out !== e) begin
                    n_fail++;
                    $display("FAIL %s: pwm_out=%b expected=%b at %0t", t, pwm_out, e, $time);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_sh[0] = '0; m_sh[1] = '0; m_act[0] = '0; m_act[1] = '0; m_out = '0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (pwm_out !== 2'b00) begin
            n_fail++;
            $display("FAIL R1: pwm_out=%b expected=00 in reset", pwm_out);
        end
        rst_n = 1'b1;
        // R1: nothing configured, a full ramp must keep both outputs low
        ramp(1, "R1");
        // R8: new word is only shadowed; events before the load point do nothing
        write(1'b0, 20'h0000A, "R8");
        idle(16'd8, 1'b1, "R8");
        idle(16'd3, 1'b1, "R8");
        // R8: load clock uses old active word, write in that clock is not loaded
        step(16'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00005, 1'b0, 1'b0, 2'b00, "R8");
        // R3: zero sets and period clears on output 0
        ramp(2, "R3");
        // R2: toggle on zero and period
        write(1'b0, 20'h0000F, "R2");
        ramp(3, "R2");
        // R4: compare A up sets, down clears
        write(1'b0, 20'h00060, "R4");
        ramp(2, "R4");
        // R5: compare B up clears, down sets, output 1 toggles on compare A up
        write(1'b0, 20'h00900, "R5");
        write(1'b1, 20'h00030, "R7");
        ramp(2, "R5");
        // R7: differing words per output, then rewrite only output 1
        write(1'b0, 20'h0006A, "R7");
        write(1'b1, 20'h00995, "R7");
        ramp(2, "R7");
        write(1'b1, 20'h00000, "R7");
        ramp(1, "R7");
        // R6: triggers in both directions
        write(1'b0, 20'h96000, "R6");
        write(1'b1, 20'h69000, "R6");
        ramp(1, "R6");
        for (int k = 0; k < 4; k++) begin
            step(16'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 2'b00, "R6");
            step(16'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 2'b00, "R6");
            step(16'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 2'b00, "R6");
            step(16'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 2'b00, "R6");
        end
        // R9: period becomes a load point
        load_at_prd = 1'b1;
        write(1'b0, 20'h00006, "R9");
        write(1'b1, 20'h00009, "R9");
        for (int c = 1; c <= 8; c++) idle(c[CW-1:0], 1'b1, "R9");
        idle(16'd8, 1'b0, "R9");
        ramp(1, "R9");
        load_at_prd = 1'b0;
        // R10: compare A, B and zero stacked, triggers on top
        cmp_a = 16'd0; cmp_b = 16'd0;
        write(1'b0, 20'h6A92E, "R10");
        write(1'b1, 20'h95E61, "R10");
        ramp(2, "R10");
        for (int k = 0; k < 4; k++) begin
            step(16'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 2'b00, "R10");
            step(16'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 2'b00, "R10");
            step(16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 2'b00, "R10");
            step(16'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 2'b00, "R10");
        end
        cmp_a = 16'd3; cmp_b = 16'd5;
        ramp(1, "R10");
        // R11: force each code on each output, with and without events
        for (int k = 0; k < 4; k++) begin
            step(16'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1, k[0], k[1:0], "R11");
            step(16'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1, ~k[0], 2'b11, "R11");
            idle(16'd2, 1'b1, "R11");
        end
        ramp(1, "R11");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule